// File: doc/BRIEF.md
# Two-Wire Register Access Target

This block is a slave-only two-wire serial bus target. It gives a bus master read and write access to an external bank of up to 128 byte-wide registers. The block samples the bus clock and data lines with a fast system clock. It finds START, repeated START and STOP, and it compares the first byte of each transfer with its 7-bit device address. It acknowledges bytes by pulling the data line low through an open-drain enable. It never drives the line high.

After the device address, a write transfer carries a register address byte. That byte holds a 7-bit register pointer and an auto-increment enable bit. The block presents the pointer, the write data and single-cycle write and read strobes to the register bank. The bank returns read data one cycle after the read strobe. The pointer and the auto-increment setting stay in place between transfers. A read with no register address byte therefore returns the register at the pointer that the previous access left.

The controller is one state machine with eleven states:
- IDLE
- DEV_ADDR (receive device byte)
- DEV_ACK
- REG_ADDR (receive register address byte)
- REG_ACK
- WR_DATA
- WR_ACK
- RD_LOAD (read strobe)
- RD_WAIT (capture bank data)
- RD_DATA (shift out)
- RD_ACK (sample master acknowledge)

The transitions are as follows:
- STOP from any state goes to IDLE.
- START from any state goes to DEV_ADDR.
- DEV_ADDR goes to DEV_ACK on a match and to IDLE on a mismatch.
- DEV_ACK goes to REG_ADDR for a write or to RD_LOAD for a read.
- REG_ADDR → REG_ACK → WR_DATA.
- WR_DATA ↔ WR_ACK.
- RD_LOAD → RD_WAIT → RD_DATA → RD_ACK.
- RD_ACK goes to RD_LOAD on an acknowledge and to IDLE on a not-acknowledge.

Top module: `i2c_reg_target`

## Requirements
- R1: The device address is 1,1,1,0,0 in bits 6:2 and `dev_strap[1:0]` in bits 1:0. The first byte after a START or repeated START carries this address in bits 7:1 and R/W in bit 0 (0 = write, 1 = read). On a match the block drives SDA low during the ninth clock.
- R2: On an address mismatch the block does not acknowledge. It issues no strobe, leaves the pointer unchanged and ignores the bus until the next START.
- R3: In a write transfer the second byte is the register address byte: bit 7 is INC and bits 6:0 are the pointer. The block acknowledges it. Each following data byte is acknowledged and produces exactly one single-cycle `reg_we` pulse, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte.
- R4: With INC=1 the pointer advances by one after each data byte written or read. It wraps from 127 to 0.
- R5: With INC=0 the pointer stays fixed, so every data byte writes or reads the same register.
- R6: A random read works as follows: device byte with R/W=0, register address byte, repeated START, device byte with R/W=1. It returns the register at the new pointer, MSB first. The block issues one single-cycle `reg_re` per byte and takes `reg_rdata` one cycle after the strobe.
- R7: The pointer and INC persist across transfers. A current-address read (START, device byte with R/W=1, data) returns the register at the pointer left by the previous access.
- R8: The block sends another byte only when the master acknowledged the previous one. After a not-acknowledge it releases SDA and issues no further read strobe. With INC=1 the pointer has still advanced past the last byte.
- R9: After reset the pointer is 0, INC is 0, SDA is released and no strobe is active. A STOP or START that arrives in the middle of a byte abandons that byte without writing it.
- R10: The SDA drive enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| dev_strap | input | 2 | Low two bits of the device address |
| reg_addr | output | 7 | Register pointer presented to the bank |
| reg_wdata | output | 8 | Byte to write |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Bank read data, valid the cycle after `reg_re` |

## Verification
A wrong state in this block shows up on the SDA line or the strobes within one bus bit. A missed acknowledge or a stray one appears in the ninth clock of the byte in question. A pointer that is off by one or fails to wrap appears on `reg_addr` in the cycle after the strobe that should have moved it. The bench sees it at the next read-back. A read path that is out of step corrupts the first bit shifted out, and the master sees that as a wrong byte value before the byte ends.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV_ADDR,
        ST_DEV_ACK,
        ST_REG_ADDR,
        ST_REG_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_RD_LOAD,
        ST_RD_WAIT,
        ST_RD_DATA,
        ST_RD_ACK
    } tgt_state_t;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_lane
        logic [STAGES-1:0] chain;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '1;   // idle bus level is high
            end else begin
                chain <= {chain[STAGES-2:0], d[g]};
            end
        end

        assign q[g] = chain[STAGES-1];
    end

endmodule

// File: rtl/i2c_tgt_cond.sv
module i2c_tgt_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    // data edges only count while the clock stays high
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_tgt_ptr.sv
module i2c_tgt_ptr #(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_ptr,
    input  logic          load_inc,
    input  logic          step,
    output logic [AW-1:0] ptr,
    output logic          inc_en
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr    <= '0;
            inc_en <= 1'b0;
        end else if (load) begin
            ptr    <= load_ptr;
            inc_en <= load_inc;
        end else if (step && inc_en) begin
            ptr <= ptr + AW'(1);   // natural wrap at the top
        end
    end

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
    import i2c_tgt_pkg::*;
#(
    parameter int         REG_AW      = 7,
    parameter int         DATA_W      = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [4:0] DEV_ID_HI   = 5'b11100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [1:0]        dev_strap,
    output logic [REG_AW-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    input  logic [DATA_W-1:0] reg_rdata
);

    localparam int              CNT_W    = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] TX_LAST  = CNT_W'(DATA_W - 1);

    // synchronised bus lines
    logic [1:0] sync_q;
    logic       scl_s;
    logic       sda_s;

    i2c_tgt_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_i, sda_i}),
        .q     (sync_q)
    );

    assign scl_s = sync_q[1];
    assign sda_s = sync_q[0];

    logic scl_rise;
    logic scl_fall;
    logic start_det;
    logic stop_det;

    i2c_tgt_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    // state and datapath
    tgt_state_t        state;
    tgt_state_t        state_nx;
    logic [DATA_W-1:0] shreg;
    logic [CNT_W-1:0]  bit_cnt;
    logic              rw_q;
    logic              mack_q;
    logic              we_q;
    logic [DATA_W-1:0] wdata_q;
    logic              byte_done;
    logic              dev_match;
    logic              ptr_load;
    logic              ptr_step;
    logic              inc_en;
    logic              sda_oe_c;
    logic              re_c;

    assign byte_done = (bit_cnt == BYTE_END);
    assign dev_match = (shreg[DATA_W-1:1] == {DEV_ID_HI, dev_strap});

    // pointer register
    assign ptr_load = (state == ST_REG_ADDR) && (state_nx == ST_REG_ACK);
    assign ptr_step = we_q || ((state == ST_RD_ACK) && scl_rise);

    i2c_tgt_ptr #(
        .AW (REG_AW)
    ) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_ptr (shreg[REG_AW-1:0]),
        .load_inc (shreg[DATA_W-1]),
        .step     (ptr_step),
        .ptr      (reg_addr),
        .inc_en   (inc_en)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        if (stop_det) begin
            state_nx = ST_IDLE;
        end else if (start_det) begin
            state_nx = ST_DEV_ADDR;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_DEV_ADDR: begin
                    if (scl_fall && byte_done) begin
                        state_nx = dev_match ? ST_DEV_ACK : ST_IDLE;
                    end
                end
                ST_DEV_ACK: begin
                    if (scl_fall) begin
                        state_nx = rw_q ? ST_RD_LOAD : ST_REG_ADDR;
                    end
                end
                ST_REG_ADDR: begin
                    if (scl_fall && byte_done) state_nx = ST_REG_ACK;
                end
                ST_REG_ACK: begin
                    if (scl_fall) state_nx = ST_WR_DATA;
                end
                ST_WR_DATA: begin
                    if (scl_fall && byte_done) state_nx = ST_WR_ACK;
                end
                ST_WR_ACK: begin
                    if (scl_fall) state_nx = ST_WR_DATA;
                end
                ST_RD_LOAD: state_nx = ST_RD_WAIT;
                ST_RD_WAIT: state_nx = ST_RD_DATA;
                ST_RD_DATA: begin
                    if (scl_fall && (bit_cnt == TX_LAST)) state_nx = ST_RD_ACK;
                end
                ST_RD_ACK: begin
                    if (scl_fall) begin
                        state_nx = mack_q ? ST_RD_LOAD : ST_IDLE;
                    end
                end
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // shift register, bit counter and strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
            rw_q    <= 1'b0;
            mack_q  <= 1'b0;
            we_q    <= 1'b0;
            wdata_q <= '0;
        end else begin
            we_q <= (state == ST_WR_DATA) && (state_nx == ST_WR_ACK);
            if ((state == ST_WR_DATA) && (state_nx == ST_WR_ACK)) begin
                wdata_q <= shreg;
            end
            if ((state == ST_DEV_ADDR) && scl_fall && byte_done) begin
                rw_q <= shreg[0];
            end
            if (start_det || stop_det) begin
                bit_cnt <= '0;
            end else begin
                unique case (state)
                    ST_DEV_ADDR, ST_REG_ADDR, ST_WR_DATA: begin
                        if (scl_rise) begin
                            shreg   <= {shreg[DATA_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + CNT_W'(1);
                        end else if (scl_fall && byte_done) begin
                            bit_cnt <= '0;
                        end
                    end
                    ST_RD_WAIT: begin
                        shreg   <= reg_rdata;
                        bit_cnt <= '0;
                    end
                    ST_RD_DATA: begin
                        if (scl_fall) begin
                            shreg   <= {shreg[DATA_W-2:0], 1'b0};
                            bit_cnt <= bit_cnt + CNT_W'(1);
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) mack_q <= ~sda_s;
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        sda_oe_c = 1'b0;
        re_c     = 1'b0;
        unique case (state)
            ST_DEV_ACK, ST_REG_ACK, ST_WR_ACK: sda_oe_c = 1'b1;
            ST_RD_DATA: sda_oe_c = ~shreg[DATA_W-1];
            ST_RD_LOAD: re_c = 1'b1;
            default: ;
        endcase
    end

    assign sda_oe    = sda_oe_c;
    assign reg_re    = re_c;
    assign reg_we    = we_q;
    assign reg_wdata = wdata_q;

endmodule

// File: rtl/i2c_tgt_checker.sv
module i2c_tgt_checker #(
    parameter int REG_AW = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_lvl,
    input logic              sda_oe,
    input logic              reg_we,
    input logic              reg_re,
    input logic [REG_AW-1:0] reg_addr,
    input logic              ptr_load
);

    AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_lvl);                                  // R10

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_re));                                            // R3

    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);                                             // R3

    AST_WE_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> $stable(reg_addr));                                   // R3

    AST_RE_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |=> ($stable(reg_addr) && !reg_re));                      // R6

    AST_PTR_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(reg_addr) && !$past(ptr_load))
            |-> (reg_addr == $past(reg_addr) + REG_AW'(1)));             // R4

endmodule

bind i2c_reg_target i2c_tgt_checker #(.REG_AW(REG_AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_lvl  (scl_s),
    .sda_oe   (sda_oe),
    .reg_we   (reg_we),
    .reg_re   (reg_re),
    .reg_addr (reg_addr),
    .ptr_load (ptr_load)
);

// File: tb/tb_i2c_reg_target.sv
module tb_i2c_reg_target;

    localparam int Q = 10;
    localparam logic [6:0] DEV = 7'b1110010;
    localparam logic [6:0] BAD = 7'b1110001;

    typedef struct packed {
        logic [6:0] a;
        logic [7:0] d;
    } vec_t;

    localparam vec_t VEC [0:5] = '{
        '{7'h00, 8'hA5}, '{7'h7F, 8'h5A}, '{7'h13, 8'hFF},
        '{7'h40, 8'h00}, '{7'h2A, 8'h81}, '{7'h55, 8'h3C}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic [1:0] strap = 2'b10;
    logic       sda_oe;
    logic [6:0] reg_addr;
    logic [7:0] reg_wdata;
    logic       reg_we;
    logic       reg_re;
    logic [7:0] rdata_q;

    always #5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2c_reg_target dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .dev_strap (strap),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_re    (reg_re),
        .reg_rdata (rdata_q)
    );

    // register bank model with one-cycle read latency
    logic [7:0] mem [0:127];
    int we_cnt = 0;
    int re_cnt = 0;
    int oe_viol = 0;
    logic oe_prev = 1'b0;

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = 8'(i) ^ 8'h3C;
        rdata_q = 8'h00;
    end

    always @(posedge clk) begin
        if (reg_we) mem[reg_addr] <= reg_wdata;
        if (reg_re) rdata_q <= mem[reg_addr];
        if (rst_n && reg_we) we_cnt++;
        if (rst_n && reg_re) re_cnt++;
    end

    always @(negedge clk) begin
        if (rst_n && (sda_oe != oe_prev) && scl_m) oe_viol++;
        oe_prev = sda_oe;
    end

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic hw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hw();
        scl_m = 1'b1; hw();
        sda_m = 1'b0; hw();
        scl_m = 1'b0; hw();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hw();
        scl_m = 1'b1; hw();
        sda_m = 1'b1; hw();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    hw();
        scl_m = 1'b1; hw();
        scl_m = 1'b0; hw();
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; hw();
        scl_m = 1'b1; hw();
        ack = ~sda_line;
        scl_m = 1'b0; hw();
    endtask

    task automatic rd_byte(input logic mack, output logic [7:0] b);
        b = 8'h00;
        for (int i = 0; i < 8; i++) begin
            sda_m = 1'b1; hw();
            scl_m = 1'b1; hw();
            b = {b[6:0], sda_line};
            scl_m = 1'b0; hw();
        end
        send_bit(~mack);
    endtask

    task automatic reg_write(input logic [6:0] dv, input logic inc, input logic [6:0] a,
                             input logic [7:0] d [0:3], input int n, output int n_ack);
        logic k;
        n_ack = 0;
        bus_start();
        wr_byte({dv, 1'b0}, k); n_ack += int'(k);
        wr_byte({inc, a}, k);   n_ack += int'(k);
        for (int i = 0; i < n; i++) begin
            wr_byte(d[i], k); n_ack += int'(k);
        end
        bus_stop();
    endtask

    task automatic reg_read(input logic [6:0] dv, input logic rnd, input logic inc,
                            input logic [6:0] a, input int n,
                            output logic [7:0] q [0:3], output int n_ack);
        logic k;
        n_ack = 0;
        bus_start();
        if (rnd) begin
            wr_byte({dv, 1'b0}, k); n_ack += int'(k);
            wr_byte({inc, a}, k);   n_ack += int'(k);
            bus_start();
        end
        wr_byte({dv, 1'b1}, k); n_ack += int'(k);
        for (int i = 0; i < n; i++) rd_byte(i < n - 1, q[i]);
        bus_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d [0:3];
        logic [7:0] q [0:3];
        int         na;
        int         w0;
        int         r0;
        logic [7:0] keep;
        logic [6:0] p0;

        for (int i = 0; i < 4; i++) begin d[i] = 8'h00; q[i] = 8'h00; end

        // R9 reset state
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 reset sda_oe", sda_oe, 0);
        chk("R9 reset reg_we", reg_we, 0);
        chk("R9 reset reg_re", reg_re, 0);
        chk("R9 reset pointer", reg_addr, 0);

        // R1 R3 R6 vector table: single write then random read-back
        for (int v = 0; v < 6; v++) begin
            d[0] = VEC[v].d;
            reg_write(DEV, 1'b0, VEC[v].a, d, 1, na);
            chk("R1 R3 write acks", na, 3);
            chk("R3 stored byte", mem[VEC[v].a], VEC[v].d);
            reg_read(DEV, 1'b1, 1'b0, VEC[v].a, 1, q, na);
            chk("R6 random read acks", na, 3);
            chk("R6 random read data", q[0], VEC[v].d);
        end

        // R2 address mismatch is ignored
        w0 = we_cnt; r0 = re_cnt; p0 = reg_addr;
        d[0] = 8'h11; d[1] = 8'h22;
        reg_write(BAD, 1'b1, 7'h33, d, 2, na);
        chk("R2 mismatch write acks", na, 0);
        chk("R2 mismatch no write", we_cnt - w0, 0);
        chk("R2 mismatch pointer kept", reg_addr, p0);
        reg_read(BAD, 1'b0, 1'b0, 7'h00, 1, q, na);
        chk("R2 mismatch read acks", na, 0);
        chk("R2 mismatch no read", re_cnt - r0, 0);
        chk("R2 mismatch line released", q[0], 8'hFF);

        // R4 auto-increment write with wrap
        d[0] = 8'h11; d[1] = 8'h22; d[2] = 8'h33; d[3] = 8'h44;
        reg_write(DEV, 1'b1, 7'h7E, d, 4, na);
        chk("R4 block write acks", na, 6);
        chk("R4 byte at 7E", mem[7'h7E], 8'h11);
        chk("R4 byte at 7F", mem[7'h7F], 8'h22);
        chk("R4 wrap byte at 00", mem[7'h00], 8'h33);
        chk("R4 byte at 01", mem[7'h01], 8'h44);
        chk("R4 pointer after block", reg_addr, 7'h02);

        // R4 R8 auto-increment read, not-acknowledge on last
        r0 = re_cnt;
        reg_read(DEV, 1'b1, 1'b1, 7'h7E, 3, q, na);
        chk("R4 block read 0", q[0], 8'h11);
        chk("R4 block read 1", q[1], 8'h22);
        chk("R4 block read 2", q[2], 8'h33);
        chk("R8 strobes per byte", re_cnt - r0, 3);
        chk("R8 pointer past last", reg_addr, 7'h01);

        // R7 current-address read with persisted INC
        reg_read(DEV, 1'b0, 1'b0, 7'h00, 1, q, na);
        chk("R7 current read ack", na, 1);
        chk("R7 current read data", q[0], 8'h44);
        chk("R7 INC persisted", reg_addr, 7'h02);

        // R5 fixed pointer write
        keep = mem[7'h11];
        w0 = we_cnt;
        d[0] = 8'h01; d[1] = 8'h02; d[2] = 8'h03;
        reg_write(DEV, 1'b0, 7'h10, d, 3, na);
        chk("R5 fixed write acks", na, 5);
        chk("R5 one strobe per byte", we_cnt - w0, 3);
        chk("R5 last byte kept", mem[7'h10], 8'h03);
        chk("R5 neighbour untouched", mem[7'h11], keep);
        chk("R5 pointer fixed", reg_addr, 7'h10);

        // R7 R5 current-address read of two bytes, same register
        reg_read(DEV, 1'b0, 1'b0, 7'h00, 2, q, na);
        chk("R7 current read first", q[0], 8'h03);
        chk("R5 current read repeat", q[1], 8'h03);

        // R9 STOP in the middle of a data byte
        keep = mem[7'h20];
        w0 = we_cnt;
        bus_start();
        wr_byte({DEV, 1'b0}, sda_m);
        wr_byte({1'b1, 7'h20}, sda_m);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        bus_stop();
        chk("R9 stop abandons byte", we_cnt - w0, 0);
        chk("R9 stop register unchanged", mem[7'h20], keep);
        d[0] = 8'h9C;
        reg_write(DEV, 1'b0, 7'h20, d, 1, na);
        chk("R9 restart after stop acks", na, 3);
        chk("R9 restart after stop data", mem[7'h20], 8'h9C);

        // R9 repeated START in the middle of a data byte
        keep = mem[7'h21];
        w0 = we_cnt;
        bus_start();
        wr_byte({DEV, 1'b0}, sda_m);
        wr_byte({1'b0, 7'h21}, sda_m);
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        bus_start();
        wr_byte({DEV, 1'b1}, sda_m);
        rd_byte(1'b0, q[0]);
        bus_stop();
        chk("R9 restart abandons byte", we_cnt - w0, 0);
        chk("R9 restart read data", q[0], keep);

        // R10 drive enable never moved while SCL high
        chk("R10 sda change with scl high", oe_viol, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule